// File: doc/BRIEF.md
# Multi-rate TDM output serializer

This block drives a group of serial time-division-multiplexed output streams. Every stream has its own 4-bit rate code, and that code picks one of four line rates: 2.048, 4.096, 8.192 or 16.384 Mbps. All streams share one 125 µs frame. The block runs on a single 16.384 MHz clock, which is 2048 cycles per frame. For each stream it works out when each bit and each channel begins. It tells the switching memory which channel that stream needs next. At each channel boundary it loads the returned byte and shifts it out, most significant bit first.

A clock-mode input records how the line timing is sourced. In multiplied-clock mode all four rates are legal. In divided-clock mode the output is timed from an input clock, so a rate above half that clock's frequency is refused, and a refused stream stays in high impedance. The streams form a lower half and an upper half, and each half can be switched to bidirectional operation on its own. A stream in a bidirectional half drives its line only in the channels that the memory marks for driving. An active low frame pulse aligns all streams: on the next cycle every valid stream starts channel 0, bit 7.

The outputs are a data bit and an output enable for each stream, and the pad logic outside the block turns them into a tri-state line. Configuration inputs are sampled only at a frame pulse, so a whole frame always runs with one consistent setting.

Top module: `tdm_out_serializer`

## Requirements
- R1: Two conditions keep every txOe and txData bit at 0: reset is asserted, or no frame pulse (fpN low at a rising clock edge) has been sampled since reset.
- R2: The rate code 0, 1, 2 or 3 selects 2.048, 4.096, 8.192 or 16.384 Mbps. At these rates each bit lasts 8, 4, 2 or 1 clock cycles, and a 2048-cycle frame holds 32, 64, 128 or 256 channels.
- R3: Each channel sends the byte returned for that channel, MSB (bit 7) first and bit 0 last.
- R4: Suppose fpN is sampled low at an edge. In the cycle after that edge, every valid stream drives channel 0 bit 7. If no pulse arrives, the frame position wraps to channel 0 after 2048 cycles.
- R5: rdChan slice s (8 bits) gives the index of the next channel that stream s will load. rdByte and rdOe are sampled in the same cycle and must answer that index. While fpN is low, every slice is 0. Otherwise the slice is (current channel + 1) modulo the channel count of the stream's rate.
- R6: Rate codes 4 to 15 hold the stream's txOe at 0. This includes 15, the value loaded at reset, which marks a stream as unprogrammed.
- R7: With clkModeMul = 0 the input clock runs at 4.096 × 2^ckiRate MHz. A stream whose rate code is greater than ckiRate is refused and its txOe stays 0.
- R8: With clkModeMul = 1, rate codes 0 to 3 are all accepted, whatever ckiRate is.
- R9: bidirLo covers streams 0 to 15 and bidirHi covers streams 16 to 31. In a bidirectional half, txOe of a valid stream follows the rdOe bit captured with each channel's byte. In a normal half, txOe of a valid stream is 1 whatever rdOe is.
- R10: rateCfg, clkModeMul, ckiRate, bidirLo and bidirHi are sampled only at a frame pulse. They take effect from the next cycle, and changes made between frame pulses have no effect on the outputs.
- R11: Whenever txOe of a stream is 0, its txData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz bit clock |
| rstN | input | 1 | Asynchronous active low reset |
| fpN | input | 1 | Active low frame pulse, one cycle wide, in the last cycle of a frame |
| clkModeMul | input | 1 | 1 = multiplied-clock timing, 0 = divided from the input clock |
| ckiRate | input | 2 | Input clock frequency code, 4.096 × 2^code MHz |
| bidirLo | input | 1 | Bidirectional mode for the lower half of the streams |
| bidirHi | input | 1 | Bidirectional mode for the upper half of the streams |
| rateCfg | input | NUM_STREAMS×4 | Rate code per stream, stream s in bits 4s+3 to 4s |
| rdChan | output | NUM_STREAMS×8 | Next channel index per stream for the memory read |
| rdByte | input | NUM_STREAMS×8 | Channel byte for the index in rdChan |
| rdOe | input | NUM_STREAMS | Per-channel drive flag for bidirectional operation |
| txData | output | NUM_STREAMS | Serial output bit per stream |
| txOe | output | NUM_STREAMS | Output enable per stream |

## Verification
The bench goes after the frame pulse that arrives early, in the middle of a frame. A design that did not clear its position there would leave the streams out of step with one another. It also lets two full frames pass with no pulse at all, which shows the wrap at 2048 cycles. If the channel decode or the look-ahead index were off by one, the stream would send a neighbour's byte. Configuration is changed in the middle of a frame, so a design that used a new rate or mode at once, before the next frame pulse, would break the bit timing of that frame. Divided-clock settings and bidirectional halves are mixed with invalid and unprogrammed codes, so a wrong comparison against ckiRate or a group decode that picked the wrong half would show up as an enable driven at the wrong time.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;
  // number of selectable line rates, each doubling the previous one
  localparam int RATE_STEPS = 4;
  localparam int RSEL_W = $clog2(RATE_STEPS);
  localparam int BYTE_BITS = 8;
  localparam int BIT_SH = $clog2(BYTE_BITS);

  // per-stream strobes passed from control to datapath
  typedef struct packed {
    logic load;    // capture next channel byte this cycle
    logic shift;   // advance to next bit this cycle
    logic active;  // stream has a usable rate and frame alignment
    logic bidir;   // stream belongs to a bidirectional half
  } serStrobe_t;
endpackage

// File: rtl/tdm_ser_ctrl.sv
module tdm_ser_ctrl
  import tdm_ser_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int BASE_CHANS = 32,
  parameter int RATE_W = 4,
  localparam int CH_W = $clog2(BASE_CHANS << (RATE_STEPS - 1))
) (
  input  logic clk,
  input  logic rstN,
  input  logic fpN,
  input  logic clkModeMul,
  input  logic [RSEL_W-1:0] ckiRate,
  input  logic bidirLo,
  input  logic bidirHi,
  input  logic [NUM_STREAMS*RATE_W-1:0] rateCfg,
  output logic [NUM_STREAMS*CH_W-1:0] rdChan,
  output serStrobe_t [NUM_STREAMS-1:0] strobes
);
  localparam int MAX_SH = RATE_STEPS - 1;
  localparam int FRAME_CYC = BASE_CHANS * BYTE_BITS * (1 << MAX_SH);
  localparam int FC_W = $clog2(FRAME_CYC);
  localparam int HALF = NUM_STREAMS / 2;

  logic [FC_W-1:0] frameCnt;
  logic aligned;
  logic mulLat;
  logic [RSEL_W-1:0] ckiLat;
  logic bidLoLat;
  logic bidHiLat;
  logic [NUM_STREAMS*RATE_W-1:0] rateLat;

  // shared frame position plus configuration snapshot taken at the frame pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      aligned  <= 1'b0;
      mulLat   <= 1'b0;
      ckiLat   <= '0;
      bidLoLat <= 1'b0;
      bidHiLat <= 1'b0;
      rateLat  <= '1;
    end else if (!fpN) begin
      frameCnt <= '0;
      aligned  <= 1'b1;
      mulLat   <= clkModeMul;
      ckiLat   <= ckiRate;
      bidLoLat <= bidirLo;
      bidHiLat <= bidirHi;
      rateLat  <= rateCfg;
    end else begin
      frameCnt <= (frameCnt == FC_W'(FRAME_CYC - 1)) ? '0 : frameCnt + FC_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gStream
    logic [RATE_W-1:0] code;
    logic [RSEL_W-1:0] sel;
    logic [RSEL_W-1:0] slowSh;
    logic [FC_W-1:0] bitMask;
    logic [FC_W-1:0] chanMask;
    logic [CH_W-1:0] chanNow;
    logic [CH_W-1:0] chanLim;
    logic rateOk;
    logic clkOk;
    logic endBit;
    logic endChan;
    logic grpBidir;

    assign code    = rateLat[g*RATE_W +: RATE_W];
    assign sel     = code[RSEL_W-1:0];
    assign slowSh  = RSEL_W'(MAX_SH) - sel;
    assign bitMask = (FC_W'(1) << slowSh) - FC_W'(1);
    assign chanMask = (FC_W'(1) << (int'(slowSh) + BIT_SH)) - FC_W'(1);
    assign chanNow = CH_W'(frameCnt >> (int'(slowSh) + BIT_SH));
    assign chanLim = (CH_W'(BASE_CHANS) << sel) - CH_W'(1);
    assign rateOk  = code < RATE_W'(RATE_STEPS);
    assign clkOk   = mulLat || (sel <= ckiLat);
    assign endBit  = (frameCnt & bitMask) == bitMask;
    assign endChan = (frameCnt & chanMask) == chanMask;

    if (g < HALF) begin : gLow
      assign grpBidir = bidLoLat;
    end else begin : gHigh
      assign grpBidir = bidHiLat;
    end

    // look-ahead index: channel 0 at a frame pulse, otherwise the following channel
    assign rdChan[g*CH_W +: CH_W] = (!fpN) ? '0 : ((chanNow + CH_W'(1)) & chanLim);

    assign strobes[g] = '{
      load:   (!fpN) || endChan,
      shift:  fpN && endBit && !endChan,
      active: aligned && rateOk && clkOk,
      bidir:  grpBidir
    };
  end
endmodule

// File: rtl/tdm_ser_dp.sv
module tdm_ser_dp
  import tdm_ser_pkg::*;
#(
  parameter int NUM_STREAMS = 32
) (
  input  logic clk,
  input  logic rstN,
  input  serStrobe_t [NUM_STREAMS-1:0] strobes,
  input  logic [NUM_STREAMS*BYTE_BITS-1:0] rdByte,
  input  logic [NUM_STREAMS-1:0] rdOe,
  output logic [NUM_STREAMS-1:0] txData,
  output logic [NUM_STREAMS-1:0] txOe
);
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gLane
    logic [BYTE_BITS-1:0] shReg;
    logic oeReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg <= '0;
        oeReg <= 1'b0;
      end else if (strobes[g].load) begin
        shReg <= rdByte[g*BYTE_BITS +: BYTE_BITS];
        oeReg <= rdOe[g];
      end else if (strobes[g].shift) begin
        shReg <= {shReg[BYTE_BITS-2:0], 1'b0};
      end
    end

    assign txOe[g]   = strobes[g].active && (!strobes[g].bidir || oeReg);
    assign txData[g] = txOe[g] && shReg[BYTE_BITS-1];
  end
endmodule

// File: rtl/tdm_out_serializer.sv
module tdm_out_serializer
  import tdm_ser_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int BASE_CHANS = 32,
  parameter int RATE_W = 4,
  localparam int CH_W = $clog2(BASE_CHANS << (RATE_STEPS - 1))
) (
  input  logic clk,
  input  logic rstN,
  input  logic fpN,
  input  logic clkModeMul,
  input  logic [RSEL_W-1:0] ckiRate,
  input  logic bidirLo,
  input  logic bidirHi,
  input  logic [NUM_STREAMS*RATE_W-1:0] rateCfg,
  output logic [NUM_STREAMS*CH_W-1:0] rdChan,
  input  logic [NUM_STREAMS*BYTE_BITS-1:0] rdByte,
  input  logic [NUM_STREAMS-1:0] rdOe,
  output logic [NUM_STREAMS-1:0] txData,
  output logic [NUM_STREAMS-1:0] txOe
);
  serStrobe_t [NUM_STREAMS-1:0] strobes;

  tdm_ser_ctrl #(
    .NUM_STREAMS(NUM_STREAMS),
    .BASE_CHANS(BASE_CHANS),
    .RATE_W(RATE_W)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .fpN(fpN),
    .clkModeMul(clkModeMul),
    .ckiRate(ckiRate),
    .bidirLo(bidirLo),
    .bidirHi(bidirHi),
    .rateCfg(rateCfg),
    .rdChan(rdChan),
    .strobes(strobes)
  );

  tdm_ser_dp #(
    .NUM_STREAMS(NUM_STREAMS)
  ) i_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .rdByte(rdByte),
    .rdOe(rdOe),
    .txData(txData),
    .txOe(txOe)
  );
endmodule

// File: rtl/tdm_ser_chk.sv
module tdm_ser_chk
  import tdm_ser_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int BASE_CHANS = 32,
  parameter int RATE_W = 4
) (
  input logic clk,
  input logic rstN,
  input logic fpN,
  input logic clkModeMul,
  input logic [RSEL_W-1:0] ckiRate,
  input logic bidirLo,
  input logic bidirHi,
  input logic [NUM_STREAMS*RATE_W-1:0] rateCfg,
  input logic [NUM_STREAMS-1:0] txData,
  input logic [NUM_STREAMS-1:0] txOe
);
  localparam int MAX_SH = RATE_STEPS - 1;
  localparam int FRAME_CYC = BASE_CHANS * BYTE_BITS * (1 << MAX_SH);
  localparam int FC_W = $clog2(FRAME_CYC);

  // independent shadow of frame position and the configuration in force
  logic seen;
  logic mulS;
  logic bLoS;
  logic bHiS;
  logic [RSEL_W-1:0] ckiS;
  logic [NUM_STREAMS*RATE_W-1:0] rateS;
  logic [FC_W-1:0] pos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen  <= 1'b0;
      mulS  <= 1'b0;
      bLoS  <= 1'b0;
      bHiS  <= 1'b0;
      ckiS  <= '0;
      rateS <= '1;
      pos   <= '0;
    end else if (!fpN) begin
      seen  <= 1'b1;
      mulS  <= clkModeMul;
      bLoS  <= bidirLo;
      bHiS  <= bidirHi;
      ckiS  <= ckiRate;
      rateS <= rateCfg;
      pos   <= '0;
    end else begin
      pos <= (pos == FC_W'(FRAME_CYC - 1)) ? '0 : pos + FC_W'(1);
    end
  end

  assert_prealign_R1: assert property (@(posedge clk) disable iff (!rstN)
    !seen |-> (txOe == '0));

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gChk
    logic [RATE_W-1:0] code;
    logic [RSEL_W-1:0] sel;
    logic [FC_W-1:0] holdMask;
    logic codeOk;
    logic grpB;

    assign code     = rateS[g*RATE_W +: RATE_W];
    assign sel      = code[RSEL_W-1:0];
    assign codeOk   = code < RATE_W'(RATE_STEPS);
    assign holdMask = (FC_W'(1) << (RSEL_W'(MAX_SH) - sel)) - FC_W'(1);
    assign grpB     = (g < NUM_STREAMS / 2) ? bLoS : bHiS;

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      (seen && codeOk && ((pos & holdMask) != '0)) |-> $stable(txData[g]));

    assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rstN)
      (seen && !codeOk) |-> !txOe[g]);

    assert_div_refuse_R7: assert property (@(posedge clk) disable iff (!rstN)
      (seen && codeOk && !mulS && (sel > ckiS)) |-> !txOe[g]);

    assert_mul_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
      (seen && codeOk && mulS && !grpB) |-> txOe[g]);
  end
endmodule

bind tdm_out_serializer tdm_ser_chk #(
  .NUM_STREAMS(NUM_STREAMS),
  .BASE_CHANS(BASE_CHANS),
  .RATE_W(RATE_W)
) i_chk (
  .clk(clk),
  .rstN(rstN),
  .fpN(fpN),
  .clkModeMul(clkModeMul),
  .ckiRate(ckiRate),
  .bidirLo(bidirLo),
  .bidirHi(bidirHi),
  .rateCfg(rateCfg),
  .txData(txData),
  .txOe(txOe)
);

// File: tb/test_tdm_out_serializer.sv
module test_tdm_out_serializer;
  import tdm_ser_pkg::*;

  localparam int CLK_PERIOD = 62;
  localparam int NS = 32;
  localparam int BC = 32;
  localparam int RW = 4;
  localparam int CHW = 8;
  localparam int FRAME = 2048;
  localparam int WATCHDOG = 40000;

  logic clk;
  logic rstN;
  logic fpN;
  logic clkModeMul;
  logic [1:0] ckiRate;
  logic bidirLo;
  logic bidirHi;
  logic [NS*RW-1:0] rateCfg;
  logic [NS*CHW-1:0] rdChan;
  logic [NS*8-1:0] rdByte;
  logic [NS-1:0] rdOe;
  logic [NS-1:0] txData;
  logic [NS-1:0] txOe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference state
  int pos;
  bit aligned;
  bit mulM;
  int ckiM;
  bit bLoM;
  bit bHiM;
  int rateM [NS];

  tdm_out_serializer #(
    .NUM_STREAMS(NS),
    .BASE_CHANS(BC),
    .RATE_W(RW)
  ) i_tdm_out_serializer (
    .clk(clk),
    .rstN(rstN),
    .fpN(fpN),
    .clkModeMul(clkModeMul),
    .ckiRate(ckiRate),
    .bidirLo(bidirLo),
    .bidirHi(bidirHi),
    .rateCfg(rateCfg),
    .rdChan(rdChan),
    .rdByte(rdByte),
    .rdOe(rdOe),
    .txData(txData),
    .txOe(txOe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memByte(int s, int ch);
    return 8'((s * 37 + ch * 11 + 5) ^ (ch * 3));
  endfunction

  function automatic logic memOe(int s, int ch);
    return ((s + ch) % 3) != 0;
  endfunction

  // switching memory stand-in: answers the requested index in the same cycle
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      rdByte[s*8 +: 8] = memByte(s, int'(rdChan[s*CHW +: CHW]));
      rdOe[s] = memOe(s, int'(rdChan[s*CHW +: CHW]));
    end
  end

  task automatic check(string tag, int s, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s stream %0d pos %0d: actual %0d expected %0d", tag, s, pos, act, exp);
    end
  endtask

  task automatic compareAll();
    for (int s = 0; s < NS; s++) begin
      int code = rateM[s];
      int r = code & 3;
      int len = 64 >> r;
      int per = 8 >> r;
      int ch = pos / len;
      int b = (pos % len) / per;
      int expCh = 0;
      bit rateOk = code < 4;
      bit valid = aligned && (code < 4) && (mulM || (r <= ckiM));
      bit grp = (s < NS/2) ? bLoM : bHiM;
      bit pend = (int'(rateCfg[s*RW +: RW]) != code) || (clkModeMul != mulM) ||
                 (int'(ckiRate) != ckiM) || (bidirLo != bLoM) || (bidirHi != bHiM);
      logic [7:0] byt = memByte(s, ch);
      bit expOe = 1'b0;
      bit expD = 1'b0;
      string tag;
      if (valid) begin
        expOe = grp ? memOe(s, ch) : 1'b1;
        expD = expOe & byt[7-b];
      end
      if (!aligned) tag = "R1";
      else if (!rateOk) tag = "R6";
      else if (!mulM && r > ckiM) tag = "R7";
      else if (pend) tag = "R10";
      else if (grp) tag = "R9";
      else if (pos == 0) tag = "R4";
      else if (mulM && r >= 2) tag = "R8";
      else if ((pos % per) != 0) tag = "R2";
      else tag = "R3";
      check(tag, s, int'({txOe[s], txData[s]}), int'({expOe, expD}));
      if (aligned && rateOk) begin
        expCh = (!fpN) ? 0 : ((ch + 1) % (BC << r));
        check("R5", s, int'(rdChan[s*CHW +: CHW]), expCh);
      end
      if (!txOe[s]) check("R11", s, int'(txData[s]), 0);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      pos = 0; aligned = 0; mulM = 0; ckiM = 0; bLoM = 0; bHiM = 0;
      for (int s = 0; s < NS; s++) rateM[s] = 15;
    end else if (!fpN) begin
      pos = 0; aligned = 1; mulM = clkModeMul; ckiM = int'(ckiRate);
      bLoM = bidirLo; bHiM = bidirHi;
      for (int s = 0; s < NS; s++) rateM[s] = int'(rateCfg[s*RW +: RW]);
    end else begin
      pos = (pos + 1) % FRAME;
    end
    #(CLK_PERIOD/4);
    if (rstN && !finished) compareAll();
  end

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(int n);
    for (int k = 0; k < n; k++) begin
      fpN = 1'b0;
      @(negedge clk);
      fpN = 1'b1;
      runCycles(FRAME - 1);
    end
  endtask

  // rates rotated by shift for streams 0..23, fixed invalid and mixed codes above
  task automatic setRates(int shift);
    for (int s = 0; s < NS; s++) begin
      int code;
      if (s < 24) code = (s + shift) % 4;
      else if (s < 28) code = (s == 24) ? 4 : (s == 25) ? 7 : (s == 26) ? 9 : 15;
      else code = 31 - s;
      rateCfg[s*RW +: RW] = RW'(code);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rstN = 1'b0; fpN = 1'b1; clkModeMul = 1'b1; ckiRate = 2'd0;
    bidirLo = 1'b0; bidirHi = 1'b0; rateCfg = '1;
    repeat (4) @(negedge clk);
    check("R1", 0, int'(txOe), 0);
    check("R1", 0, int'(txData), 0);
    rstN = 1'b1;
    runCycles(100);
    // multiplied clock, every rate, invalid and unprogrammed codes
    setRates(0);
    frames(2);
    // change in mid-frame must wait for the next pulse
    fpN = 1'b0; @(negedge clk); fpN = 1'b1;
    runCycles(700);
    setRates(1); clkModeMul = 1'b0; ckiRate = 2'd1; bidirLo = 1'b1;
    runCycles(FRAME - 1 - 700);
    frames(2);
    // divided clock at a higher input rate, upper half bidirectional
    ckiRate = 2'd2; bidirLo = 1'b0; bidirHi = 1'b1; setRates(2);
    frames(1);
    // early frame pulse realigns all streams
    ckiRate = 2'd3; bidirLo = 1'b1; setRates(3);
    fpN = 1'b0; @(negedge clk); fpN = 1'b1;
    runCycles(1000);
    frames(1);
    // no pulses: position wraps by itself
    clkModeMul = 1'b1; bidirLo = 1'b0; bidirHi = 1'b0;
    runCycles(FRAME * 2);
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      summary();
    end
  end
endmodule